// File: doc/BRIEF.md
# Lockable Seconds Counter

This block keeps wall-clock time as a 48-bit count of seconds. A tick-enable input marks each cycle of a slow reference clock, nominally 32768 per second. A prescaler turns those ticks into whole seconds. Once in every hour of counted seconds, the length of one second is stretched or shortened by a signed trim value, so that software can correct the drift of the reference oscillator.

Software reaches the block over a simple 32-bit register bus with one-cycle read latency. The count is exposed as a 32-bit low word and a 16-bit high word. Every register write is ignored until a two-word key sequence has been written in the right order. After that, the block stays open until reset.

A snapshot mode keeps word-wise reads coherent: in that mode, a read of the low word captures the high word, and the next read of the high word returns the captured value and releases it. Software loads a new time by writing the low word and then the high word. The load takes effect on the high-word write and restarts the sub-second phase.

Top module: `secs_lock_counter`

## Requirements
- R1: After reset the count is 0, the block is locked, and the count words, the trim register (0x10) and the control register (0x50) all read 0.
- R2: While locked, writes to the count words, the trim register and the control register have no effect.
- R3: Writing 0x83E70B13 to offset 0x70 and then 0x95A4F1E0 to offset 0x74 opens the block, and control bit 23 then reads 1 until reset.
- R4: A wrong value written to either key offset, or the second key written without the first, returns the key sequence to its start and leaves the block locked.
- R5: A write to the low word (0x08) only stages the value. A following write to the high word (0x0C) loads {high[15:0], staged low} into the count, and bits 31:16 of that high-word write are ignored.
- R6: A load restarts the sub-second prescaler and the hour phase, so the next increment comes after one full second of ticks.
- R7: With zero trim the count rises by exactly one, with carry from the low word into the high word, on every TICKS_PER_SEC-th tick.
- R8: The first second of each hour of SECS_PER_HOUR seconds lasts TICKS_PER_SEC + trim ticks, where trim is signed two's complement and the sum is clamped to at least 1. The trim register reads back as written.
- R9: With control bits 25:24 equal to 2, a low-word read captures the high word; the next high-word read returns the captured value and releases it, so a later high-word read returns the live value.
- R10: With control bits 25:24 not equal to 2, a high-word read returns the live high word.
- R11: Read data appears in the cycle after the read strobe. It is zero for the key offsets, for unmapped offsets, and in any cycle that follows no read.
- R12: Control bits 25:24 are writable and read back. All other control bits read 0, except bit 23, which is the read-only open flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One reference tick in this cycle |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W (7) | Byte offset of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, valid the cycle after bus_rd |

## Verification
Counting is tried with four kinds of trim, and each separates a different fault:
- Zero trim checks the plain prescaler and the low-to-high carry.
- A positive trim shows that only the first second of each hour is stretched.
- A small negative trim shows that such a second can be shortened.
- A large negative trim separates a correctly clamped period from one that wraps around.

The key logic is tried with a correct pair, a reversed order and a wrong value in each position, which tells a true order check from one that only compares values. The read paths are tried with a carry that falls between the two word reads, both with and without snapshot mode, which tells a coherent capture from a live read.

// File: rtl/secs_lock_pkg.sv
package secs_lock_pkg;
   // byte offsets decoded on the register bus
   localparam logic [6:0] OFS_CNT_LO = 7'h08;
   localparam logic [6:0] OFS_CNT_HI = 7'h0C;
   localparam logic [6:0] OFS_TRIM   = 7'h10;
   localparam logic [6:0] OFS_CTRL   = 7'h50;
   localparam logic [6:0] OFS_KEY_A  = 7'h70;
   localparam logic [6:0] OFS_KEY_B  = 7'h74;

   localparam logic [31:0] KEY_A_VAL = 32'h83E7_0B13;
   localparam logic [31:0] KEY_B_VAL = 32'h95A4_F1E0;

   localparam int OPEN_BIT = 23;
   localparam int MODE_LSB = 24;
   localparam logic [1:0] MODE_SNAP = 2'd2;

   typedef enum logic [1:0] {
      KEY_IDLE  = 2'd0,
      KEY_ARMED = 2'd1,
      KEY_OPEN  = 2'd2
   } key_state_t;
endpackage

// File: rtl/secs_key_gate.sv
module secs_key_gate
   import secs_lock_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_a_wr,
   input  logic              key_b_wr,
   input  logic [DATA_W-1:0] wdata,
   output logic              unlocked
);
   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("secs_key_gate: keys are 32 bits wide");
      end
   endgenerate

   key_state_t st_q, st_d;
   logic a_match, b_match;

   assign a_match = (wdata == DATA_W'(KEY_A_VAL));
   assign b_match = (wdata == DATA_W'(KEY_B_VAL));

   always_comb begin
      st_d = st_q;
      case (st_q)
         KEY_IDLE:  if (key_a_wr && a_match) st_d = KEY_ARMED;
         KEY_ARMED: begin
            if (key_a_wr)      st_d = a_match ? KEY_ARMED : KEY_IDLE;
            else if (key_b_wr) st_d = b_match ? KEY_OPEN  : KEY_IDLE;
         end
         KEY_OPEN:  st_d = KEY_OPEN;
         default:   st_d = KEY_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= KEY_IDLE;
      else        st_q <= st_d;
   end

   assign unlocked = (st_q == KEY_OPEN);
endmodule

// File: rtl/secs_prescaler.sv
module secs_prescaler #(
   parameter int TICKS_PER_SEC = 32768,
   parameter int SECS_PER_HOUR = 3600,
   parameter int TRIM_W        = 32,
   parameter bit ENABLE_TRIM   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              restart,
   input  logic [TRIM_W-1:0] trim,
   output logic              sec_inc
);
   localparam int PER_W = TRIM_W + 2;
   localparam int HR_W  = (SECS_PER_HOUR > 2) ? $clog2(SECS_PER_HOUR) : 1;
   localparam logic [PER_W-1:0] BASE = PER_W'(TICKS_PER_SEC);

   generate
      if (TICKS_PER_SEC < 2) begin : g_bad_ticks
         $error("secs_prescaler: TICKS_PER_SEC must be at least 2");
      end
      if (SECS_PER_HOUR < 2) begin : g_bad_hour
         $error("secs_prescaler: SECS_PER_HOUR must be at least 2");
      end
      if (TRIM_W < 2) begin : g_bad_trim
         $error("secs_prescaler: TRIM_W must be at least 2");
      end
   endgenerate

   logic [PER_W-1:0] pre_q;
   logic [PER_W-1:0] period;
   logic [HR_W-1:0]  hour_q;
   logic             hour_first;

   assign hour_first = (hour_q == '0);

   generate
      if (ENABLE_TRIM) begin : g_trim
         logic signed [PER_W-1:0] adj;
         always_comb begin
            adj = $signed(BASE) + $signed({{2{trim[TRIM_W-1]}}, trim});
            if (!hour_first)
               period = BASE;
            else if (adj < $signed(PER_W'(1)))
               period = PER_W'(1);
            else
               period = adj;
         end
      end else begin : g_flat
         logic unused_trim;
         assign unused_trim = ^{trim, hour_first};
         assign period = BASE;
      end
   endgenerate

   assign sec_inc = tick_en && (pre_q >= (period - PER_W'(1)));

   always_ff @(posedge clk) begin
      if (!rst_n || restart) begin
         pre_q  <= '0;
         hour_q <= '0;
      end else if (sec_inc) begin
         pre_q  <= '0;
         hour_q <= (hour_q == HR_W'(SECS_PER_HOUR - 1)) ? '0 : hour_q + HR_W'(1);
      end else if (tick_en) begin
         pre_q  <= pre_q + PER_W'(1);
      end
   end
endmodule

// File: rtl/secs_counter.sv
module secs_counter #(
   parameter int CNT_W = 48,
   parameter int LO_W  = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sec_inc,
   input  logic                  lo_wr,
   input  logic                  hi_wr,
   input  logic [LO_W-1:0]       lo_data,
   input  logic [CNT_W-LO_W-1:0] hi_data,
   input  logic                  rd_lo,
   input  logic                  rd_hi,
   input  logic                  snap_mode,
   output logic [CNT_W-1:0]      cnt_q,
   output logic [CNT_W-LO_W-1:0] hi_view
);
   localparam int HI_W = CNT_W - LO_W;

   generate
      if (HI_W < 1 || HI_W > LO_W) begin : g_bad_split
         $error("secs_counter: high word must be 1..LO_W bits");
      end
   endgenerate

   logic [LO_W-1:0] lo_stage;
   logic [HI_W-1:0] snap_q;
   logic            hold_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         lo_stage <= '0;
         snap_q   <= '0;
         hold_q   <= 1'b0;
      end else begin
         if (lo_wr) lo_stage <= lo_data;

         if (hi_wr)        cnt_q <= {hi_data, lo_stage};
         else if (sec_inc) cnt_q <= cnt_q + CNT_W'(1);

         if (rd_hi) begin
            hold_q <= 1'b0;
         end else if (rd_lo && snap_mode) begin
            hold_q <= 1'b1;
            snap_q <= cnt_q[CNT_W-1:LO_W];
         end
      end
   end

   assign hi_view = (snap_mode && hold_q) ? snap_q : cnt_q[CNT_W-1:LO_W];
endmodule

// File: rtl/secs_lock_counter.sv
module secs_lock_counter
   import secs_lock_pkg::*;
#(
   parameter int CNT_W         = 48,
   parameter int TICKS_PER_SEC = 32768,
   parameter int SECS_PER_HOUR = 3600,
   parameter int TRIM_W        = 32,
   parameter bit ENABLE_TRIM   = 1'b1,
   parameter int ADDR_W        = 7,
   parameter int DATA_W        = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata
);
   localparam int LO_W = DATA_W;
   localparam int HI_W = CNT_W - LO_W;

   generate
      if (ADDR_W < 7) begin : g_bad_addr
         $error("secs_lock_counter: ADDR_W must reach offset 0x74");
      end
      if (TRIM_W > DATA_W) begin : g_bad_trim
         $error("secs_lock_counter: TRIM_W exceeds DATA_W");
      end
      if (DATA_W < MODE_LSB + 2) begin : g_bad_data
         $error("secs_lock_counter: DATA_W too narrow for control field");
      end
   endgenerate

   logic              key_open;
   logic              wr_ok;
   logic              lo_wr, hi_load, rd_lo, rd_hi;
   logic              sec_inc;
   logic              snap_mode;
   logic [TRIM_W-1:0] trim_q;
   logic [1:0]        mode_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [HI_W-1:0]   hi_view;
   logic [DATA_W-1:0] ctrl_view;
   logic [DATA_W-1:0] rd_mux;
   logic [DATA_W-1:0] rdata_q;

   assign wr_ok     = bus_wr && key_open;
   assign lo_wr     = wr_ok && (bus_addr == ADDR_W'(OFS_CNT_LO));
   assign hi_load   = wr_ok && (bus_addr == ADDR_W'(OFS_CNT_HI));
   assign rd_lo     = bus_rd && (bus_addr == ADDR_W'(OFS_CNT_LO));
   assign rd_hi     = bus_rd && (bus_addr == ADDR_W'(OFS_CNT_HI));
   assign snap_mode = (mode_q == MODE_SNAP);

   secs_key_gate #(.DATA_W(DATA_W)) key_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .key_a_wr (bus_wr && (bus_addr == ADDR_W'(OFS_KEY_A))),
      .key_b_wr (bus_wr && (bus_addr == ADDR_W'(OFS_KEY_B))),
      .wdata    (bus_wdata),
      .unlocked (key_open)
   );

   secs_prescaler #(
      .TICKS_PER_SEC (TICKS_PER_SEC),
      .SECS_PER_HOUR (SECS_PER_HOUR),
      .TRIM_W        (TRIM_W),
      .ENABLE_TRIM   (ENABLE_TRIM)
   ) pre_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .restart (hi_load),
      .trim    (trim_q),
      .sec_inc (sec_inc)
   );

   secs_counter #(.CNT_W(CNT_W), .LO_W(LO_W)) cnt_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .sec_inc   (sec_inc),
      .lo_wr     (lo_wr),
      .hi_wr     (hi_load),
      .lo_data   (bus_wdata),
      .hi_data   (bus_wdata[HI_W-1:0]),
      .rd_lo     (rd_lo),
      .rd_hi     (rd_hi),
      .snap_mode (snap_mode),
      .cnt_q     (cnt_q),
      .hi_view   (hi_view)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trim_q <= '0;
         mode_q <= '0;
      end else if (wr_ok) begin
         if (bus_addr == ADDR_W'(OFS_TRIM)) trim_q <= bus_wdata[TRIM_W-1:0];
         if (bus_addr == ADDR_W'(OFS_CTRL)) mode_q <= bus_wdata[MODE_LSB +: 2];
      end
   end

   always_comb begin
      ctrl_view                 = '0;
      ctrl_view[OPEN_BIT]       = key_open;
      ctrl_view[MODE_LSB +: 2]  = mode_q;
   end

   always_comb begin
      case (bus_addr)
         ADDR_W'(OFS_CNT_LO): rd_mux = cnt_q[LO_W-1:0];
         ADDR_W'(OFS_CNT_HI): rd_mux = DATA_W'(hi_view);
         ADDR_W'(OFS_TRIM):   rd_mux = DATA_W'($signed(trim_q));
         ADDR_W'(OFS_CTRL):   rd_mux = ctrl_view;
         default:             rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      rdata_q <= '0;
      else if (bus_rd) rdata_q <= rd_mux;
      else             rdata_q <= '0;
   end

   assign bus_rdata = rdata_q;
endmodule

// File: rtl/secs_lock_chk.sv
module secs_lock_chk
   import secs_lock_pkg::*;
#(
   parameter int CNT_W  = 48,
   parameter int ADDR_W = 7,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              open,
   input logic              sec_inc,
   input logic              hi_load,
   input logic [CNT_W-1:0]  cnt
);
   // R2
   locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!open && !sec_inc) |=> $stable(cnt));

   // R3
   open_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      open |=> open);

   // R4
   open_after_key_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(open) |-> $past(bus_wr && (bus_addr == ADDR_W'(OFS_KEY_B))));

   // R7
   step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_inc && !hi_load) |=> (cnt == $past(cnt) + CNT_W'(1)));

   // R11
   idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> (bus_rdata == '0));

   // R12
   ctrl_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && (bus_addr == ADDR_W'(OFS_CTRL))) |=>
         (bus_rdata[OPEN_BIT-1:0] == '0) && (bus_rdata[DATA_W-1:MODE_LSB+2] == '0));
endmodule

bind secs_lock_counter secs_lock_chk #(
   .CNT_W  (CNT_W),
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .open      (key_open),
   .sec_inc   (sec_inc),
   .hi_load   (hi_load),
   .cnt       (cnt_q)
);

// File: tb/secs_lock_counter_tb_top.sv
module secs_lock_counter_tb_top;
   localparam int TB_TICKS = 4;
   localparam int TB_HOUR  = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [6:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;

   int checks = 0;
   int errors = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic        was_rd;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   secs_lock_counter #(
      .TICKS_PER_SEC (TB_TICKS),
      .SECS_PER_HOUR (TB_HOUR)
   ) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en   (tick_en),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata)
   );

   task automatic bus_write(input logic [6:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [6:0] a, input logic [31:0] e, input string tag);
      @(negedge clk);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic ticks(input int n);
      @(negedge clk);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
   endtask

   task automatic load_time(input logic [31:0] lo, input logic [31:0] hi);
      bus_write(7'h08, lo);
      bus_write(7'h0C, hi);
   endtask

   // monitor: pops the expected value for each read issued at the previous edge
   initial begin
      forever begin
         @(posedge clk);
         was_rd = bus_rd;
         #2;
         if (was_rd) begin
            checks++;
            if (exp_q.size() == 0) begin
               errors++;
               $display("FAIL R11 unexpected read: actual=%h expected=none", bus_rdata);
            end else begin
               logic [31:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               if (bus_rdata !== e) begin
                  errors++;
                  $display("FAIL %s: actual=%h expected=%h", t, bus_rdata, e);
               end
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      bus_read(7'h08, 32'h0, "R1 low word after reset");
      bus_read(7'h0C, 32'h0, "R1 high word after reset");
      bus_read(7'h50, 32'h0, "R1 control after reset");
      bus_read(7'h10, 32'h0, "R1 trim after reset");

      // R2 writes blocked while locked
      load_time(32'h5, 32'h7);
      bus_write(7'h50, 32'h0200_0000);
      bus_write(7'h10, 32'h3);
      bus_read(7'h08, 32'h0, "R2 low word locked");
      bus_read(7'h0C, 32'h0, "R2 high word locked");
      bus_read(7'h50, 32'h0, "R2 control locked");
      bus_read(7'h10, 32'h0, "R2 trim locked");

      // R4 wrong order and wrong values
      bus_write(7'h74, 32'h95A4_F1E0);
      bus_write(7'h70, 32'h83E7_0B13);
      bus_write(7'h70, 32'h1234_5678);
      bus_write(7'h74, 32'h95A4_F1E0);
      bus_read(7'h50, 32'h0, "R4 wrong first key");
      bus_write(7'h70, 32'h83E7_0B13);
      bus_write(7'h74, 32'h95A4_F1E1);
      bus_write(7'h74, 32'h95A4_F1E0);
      bus_read(7'h50, 32'h0, "R4 wrong second key");
      load_time(32'h9, 32'h0);
      bus_read(7'h08, 32'h0, "R4 still locked");

      // R3 correct sequence
      bus_write(7'h70, 32'h83E7_0B13);
      bus_write(7'h74, 32'h95A4_F1E0);
      bus_read(7'h50, 32'h0080_0000, "R3 open flag");

      // R5 load with reserved high bits
      load_time(32'hFFFF_FFFE, 32'hABCD_0012);
      bus_read(7'h08, 32'hFFFF_FFFE, "R5 loaded low");
      bus_read(7'h0C, 32'h0000_0012, "R5 loaded high, reserved ignored");

      // R7 plain counting and carry
      ticks(TB_TICKS - 1);
      bus_read(7'h08, 32'hFFFF_FFFE, "R7 before terminal tick");
      ticks(1);
      bus_read(7'h08, 32'hFFFF_FFFF, "R7 one second");
      ticks(TB_TICKS);
      bus_read(7'h08, 32'h0, "R7 carry low");
      bus_read(7'h0C, 32'h13, "R7 carry high");

      // R6 load restarts prescaler
      ticks(2);
      load_time(32'd100, 32'h0);
      ticks(TB_TICKS - 1);
      bus_read(7'h08, 32'd100, "R6 no early increment");
      ticks(1);
      bus_read(7'h08, 32'd101, "R6 full second after load");

      // R8 positive trim: first second of each hour stretched
      bus_write(7'h10, 32'd2);
      load_time(32'd200, 32'h0);
      ticks(TB_TICKS + 1);
      bus_read(7'h08, 32'd200, "R8 stretched second not done");
      ticks(1);
      bus_read(7'h08, 32'd201, "R8 stretched second done");
      ticks(2 * TB_TICKS);
      bus_read(7'h08, 32'd203, "R8 plain seconds in hour");
      ticks(TB_TICKS + 1);
      bus_read(7'h08, 32'd203, "R8 next hour stretched");
      ticks(1);
      bus_read(7'h08, 32'd204, "R8 next hour done");

      // R8 negative trim and clamp
      bus_write(7'h10, 32'hFFFF_FFFD);
      load_time(32'd300, 32'h0);
      ticks(1);
      bus_read(7'h08, 32'd301, "R8 shortened second");
      bus_write(7'h10, 32'hFFFF_FFF6);
      load_time(32'd400, 32'h0);
      ticks(1);
      bus_read(7'h08, 32'd401, "R8 clamped period");
      bus_read(7'h10, 32'hFFFF_FFF6, "R8 trim readback");
      bus_write(7'h10, 32'h0);

      // R12 control field
      bus_write(7'h50, 32'hFFFF_FFFF);
      bus_read(7'h50, 32'h0380_0000, "R12 control all ones");
      bus_write(7'h50, 32'h0200_0000);
      bus_read(7'h50, 32'h0280_0000, "R12 snapshot mode");

      // R9 snapshot across a carry
      load_time(32'hFFFF_FFFF, 32'h5);
      bus_read(7'h08, 32'hFFFF_FFFF, "R9 low read");
      ticks(TB_TICKS);
      bus_read(7'h0C, 32'h5, "R9 captured high");
      bus_read(7'h0C, 32'h6, "R9 released high");

      // R10 live read outside snapshot mode
      bus_write(7'h50, 32'h0);
      load_time(32'hFFFF_FFFF, 32'h8);
      bus_read(7'h08, 32'hFFFF_FFFF, "R10 low read");
      ticks(TB_TICKS);
      bus_read(7'h0C, 32'h9, "R10 live high");

      // R11 key and unmapped offsets
      bus_read(7'h70, 32'h0, "R11 key offset reads zero");
      bus_read(7'h30, 32'h0, "R11 unmapped offset");

      // R5 low write only stages
      bus_write(7'h08, 32'h77);
      bus_read(7'h08, 32'h0, "R5 staged low not visible");
      bus_write(7'h0C, 32'hFFFF_0001);
      bus_read(7'h08, 32'h77, "R5 staged low loaded");
      bus_read(7'h0C, 32'h1, "R5 high loaded");

      repeat (3) @(negedge clk);
      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R11 missing read data: actual=%0d expected=0", exp_q.size());
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule